// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the clocked digital core of a LIN physical-layer interface. It turns the microcontroller's enable and transmit-data pins, a local wake pin, a synchronized bus receive level and a set of pre-debounced fault flags into four controls. These are the effective transmit command for the bus driver, the receive-data level with its output enable, and the enable of the inhibit high-side switch. Slope shaping, thresholds and the analog drivers are handled elsewhere.

With the enable pin high the controller is in its active mode. Transmit data reaches the bus only after a short settling delay, and the bus level is echoed back on the receive pin. Holding enable low for a timed window, with the wake pin steady, puts the interface to sleep. A wake pin edge or a dominant bus level in sleep is reported by pulling the receive pin low. A specific sequence of edges on enable and transmit switches the fast-baud mode on or off, and the receive pin briefly reports which of the two took place. Faults override everything on the transmit side, and a transmit pin stuck dominant is released after a timeout.

All windows are parameters counted in clock cycles: `FIRST_DOM`, `SLEEP_DLY`, `DOM_TMO`, `FLAG_LEN` and `STEP_MAX`. `SLEEP_DLY` is assumed to exceed `3*STEP_MAX`, so that a valid toggle sequence always completes before sleep is entered.

Top module: `lin_mode_ctrl`

## Requirements
- R1: Out of reset, with enable low, the transmit command is recessive (1), the receive output is enabled and echoes the bus, the inhibit switch is on and fast mode is off.
- R2: In active mode, after the settling delay, the transmit command equals the transmit pin in the same cycle (0 = dominant, 1 = recessive), and the receive output equals the bus level (1 = recessive, 0 = dominant) whatever is transmitted.
- R3: After entering active mode, the transmit command stays recessive for the first FIRST_DOM clock edges and follows the transmit pin from edge FIRST_DOM+1 on.
- R4: Enable sampled low for SLEEP_DLY+1 consecutive edges with the wake pin unchanged enters sleep: the receive output is disabled (rxd_oe_o = 0), the inhibit switch is off and the transmit command is recessive. After SLEEP_DLY edges the interface is still awake.
- R5: A change of the wake pin while enable is low and sleep is pending abandons sleep entry; the interface stays awake until enable returns high.
- R6: In sleep, a wake pin edge or a dominant bus level (bus_rx_i = 0) enables the receive output and drives it low on the next edge. Enable going high returns the interface to active mode.
- R7: A transmit pin held dominant produces a dominant command for exactly DOM_TMO cycles, after which the command is recessive.
- R8: While the undervoltage flag is set, the transmit command is recessive. The receive path is unaffected.
- R9: While the bus thermal flag is set, the transmit command and the receive output are recessive and the inhibit switch is off. Normal behaviour resumes as soon as the flag clears.
- R10: While the inhibit thermal flag is set, the inhibit switch is off and both the transmit command and the receive output are recessive.
- R11: The sequence enable falls (with transmit high), then transmit falls, then transmit rises, then enable rises, each step within STEP_MAX cycles, turns fast mode on. The receive output is then held low for FLAG_LEN cycles starting one edge after enable rises.
- R12: The same sequence while fast mode is on turns it off. The receive output is then held high for FLAG_LEN cycles regardless of the bus.
- R13: A sequence in a different order, or with any step slower than STEP_MAX cycles, leaves fast mode and the receive output unchanged.
- R14: After a timeout, the transmit command stays recessive while the transmit pin remains low. Transmission resumes only after the pin has been sampled recessive on at least one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Mode enable from the microcontroller |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| bus_rx_i | input | 1 | Synchronized bus level, 0 = dominant |
| wake_i | input | 1 | Local wake pin level |
| uv_i | input | 1 | Supply undervoltage flag |
| lin_tsd_i | input | 1 | Bus driver thermal shutdown flag |
| inh_tsd_i | input | 1 | Inhibit switch thermal shutdown flag |
| tx_cmd_o | output | 1 | Effective transmit command, 0 = dominant |
| rxd_o | output | 1 | Receive data level |
| rxd_oe_o | output | 1 | Receive output enable, 0 = high impedance |
| inh_en_o | output | 1 | Inhibit high-side switch enable |
| fast_o | output | 1 | Fast-baud mode active |

## Verification
The main data path is driven with combinations of transmit level, bus level and each fault flag. Driving transmit and bus with opposite values shows that the receive pin follows the bus and not an internal loop. Setting each flag alone, and then together, shows which outputs each flag overrides. Toggle sequences are run in the valid order, with the order broken, and with one step too slow. The bus is held recessive during the entry flag and dominant during the exit flag, so the forced level cannot be mistaken for an echo of the bus. The sleep, dominant-timeout and settling windows are each sampled one edge before and one edge after their boundary.

// File: rtl/lin_mode_pkg.sv
// Shared types for the LIN mode controller.
// Assumes: used only by the lin_mode_* modules.
package lin_mode_pkg;

    // Operating mode of the controller
    typedef enum logic [2:0] {
        M_PEND   = 3'd0,   // enable low, sleep window running
        M_NORMAL = 3'd1,   // enable high, data paths active
        M_HOLD   = 3'd2,   // enable low, sleep entry abandoned
        M_SLEEP  = 3'd3,   // asleep, receive output off
        M_WAKE   = 3'd4    // wake-up seen, reported on receive pin
    } mode_e;

    // Progress through the fast-baud toggle sequence
    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_EN_LO = 2'd1,
        T_TX_LO = 2'd2,
        T_TX_HI = 2'd3
    } tog_e;

endpackage

// File: rtl/lin_fbr_seq.sv
// Fast-baud toggle sequence detector.
// Watches for: enable falls with transmit high, transmit falls, transmit
// rises, enable rises. Each step must arrive within STEP_MAX cycles of the
// previous one. Pulses done_o (combinational) on the closing enable edge.
// Assumes: inputs already synchronized to clk.
module lin_fbr_seq
    import lin_mode_pkg::*;
#(
    parameter int STEP_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic txd_i,
    input  logic arm_ok_i,
    input  logic abort_i,
    output logic done_o
);
    localparam int SW = $clog2(STEP_MAX + 1);
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_MAX - 1);

    tog_e          st;
    logic [SW-1:0] step_cnt;
    logic          en_q;
    logic          step_over;

    // Flags a step that has waited its full allowance
    assign step_over = (step_cnt == STEP_LAST);

    // The closing enable edge completes the sequence
    assign done_o = (st == T_TX_HI) && en_i;

    // Sequence state and per-step timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= T_IDLE;
            step_cnt <= '0;
            en_q     <= 1'b0;
        end else begin
            en_q <= en_i;
            if (abort_i) begin
                st       <= T_IDLE;
                step_cnt <= '0;
            end else begin
                case (st)
                    T_IDLE: begin
                        step_cnt <= '0;
                        if (arm_ok_i && en_q && !en_i && txd_i) st <= T_EN_LO;
                    end
                    T_EN_LO: begin
                        if (en_i) begin
                            st <= T_IDLE;
                        end else if (!txd_i) begin
                            st       <= T_TX_LO;
                            step_cnt <= '0;
                        end else if (step_over) begin
                            st <= T_IDLE;
                        end else begin
                            step_cnt <= step_cnt + 1'b1;
                        end
                    end
                    T_TX_LO: begin
                        if (en_i) begin
                            st <= T_IDLE;
                        end else if (txd_i) begin
                            st       <= T_TX_HI;
                            step_cnt <= '0;
                        end else if (step_over) begin
                            st <= T_IDLE;
                        end else begin
                            step_cnt <= step_cnt + 1'b1;
                        end
                    end
                    T_TX_HI: begin
                        if (en_i || !txd_i || step_over) begin
                            st <= T_IDLE;
                        end else begin
                            step_cnt <= step_cnt + 1'b1;
                        end
                    end
                    default: st <= T_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/lin_dom_guard.sv
// Dominant-transmit timeout guard.
// Counts consecutive cycles with the transmit pin low. After DOM_TMO of them
// it raises block_o, which stays set until the pin is sampled high.
// Assumes: DOM_TMO >= 1.
module lin_dom_guard #(
    parameter int DOM_TMO = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    output logic block_o
);
    localparam int DW = $clog2(DOM_TMO + 1);
    localparam logic [DW-1:0] DOM_MAX  = DW'(DOM_TMO);
    localparam logic [DW-1:0] DOM_LAST = DW'(DOM_TMO - 1);

    logic [DW-1:0] low_cnt;

    // Saturating low-time counter and latched release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            block_o <= 1'b0;
        end else if (txd_i) begin
            low_cnt <= '0;
            block_o <= 1'b0;
        end else begin
            if (low_cnt != DOM_MAX)  low_cnt <= low_cnt + 1'b1;
            if (low_cnt == DOM_LAST) block_o <= 1'b1;
        end
    end

endmodule

// File: rtl/lin_mode_fsm.sv
// Mode sequencer: active / sleep-pending / sleep / wake-report, the
// first-dominant settling delay, the fast-baud mode bit and the status flag
// that reports fast-baud entry or exit on the receive pin.
// Assumes: wake pin low during reset (its history starts at 0).
module lin_mode_fsm
    import lin_mode_pkg::*;
#(
    parameter int FIRST_DOM = 4,
    parameter int SLEEP_DLY = 40,
    parameter int FLAG_LEN  = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  wake_i,
    input  logic  bus_rx_i,
    input  logic  seq_done_i,
    output mode_e mode_o,
    output logic  tx_ready_o,
    output logic  fast_o,
    output logic  flag_act_o,
    output logic  flag_lvl_o
);
    localparam int SLW = $clog2(SLEEP_DLY + 1);
    localparam int FLW = $clog2(FLAG_LEN + 1);
    localparam logic [SLW-1:0] SLEEP_LAST = SLW'(SLEEP_DLY - 1);
    localparam logic [FLW-1:0] FLAG_LOAD  = FLW'(FLAG_LEN);

    logic [SLW-1:0] sleep_cnt;
    logic [FLW-1:0] flag_cnt;
    logic           wake_q;
    logic           wake_evt;

    // Any change on the wake pin since the previous cycle
    assign wake_evt = (wake_i != wake_q);

    // Mode transitions and the sleep-entry window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o    <= M_PEND;
            sleep_cnt <= '0;
            wake_q    <= 1'b0;
        end else begin
            wake_q <= wake_i;
            case (mode_o)
                M_NORMAL: begin
                    sleep_cnt <= '0;
                    if (!en_i) mode_o <= M_PEND;
                end
                M_PEND: begin
                    if (en_i)                         mode_o <= M_NORMAL;
                    else if (wake_evt)                mode_o <= M_HOLD;
                    else if (sleep_cnt == SLEEP_LAST) mode_o <= M_SLEEP;
                    else                              sleep_cnt <= sleep_cnt + 1'b1;
                end
                M_HOLD: begin
                    if (en_i) mode_o <= M_NORMAL;
                end
                M_SLEEP: begin
                    if (en_i)                      mode_o <= M_NORMAL;
                    else if (wake_evt || !bus_rx_i) mode_o <= M_WAKE;
                end
                M_WAKE: begin
                    if (en_i) mode_o <= M_NORMAL;
                end
                default: mode_o <= M_PEND;
            endcase
        end
    end

    // Fast-baud mode bit and the entry/exit status flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_o     <= 1'b0;
            flag_cnt   <= '0;
            flag_lvl_o <= 1'b0;
        end else if (seq_done_i) begin
            fast_o     <= !fast_o;
            flag_cnt   <= FLAG_LOAD;
            flag_lvl_o <= fast_o;
        end else if (flag_cnt != '0) begin
            flag_cnt <= flag_cnt - 1'b1;
        end
    end

    assign flag_act_o = (flag_cnt != '0);

    // Settling delay before transmit becomes effective
    generate
        if (FIRST_DOM == 0) begin : g_no_delay
            assign tx_ready_o = (mode_o == M_NORMAL);
        end else begin : g_delay
            localparam int FDW = $clog2(FIRST_DOM + 1);
            localparam logic [FDW-1:0] FD_MAX = FDW'(FIRST_DOM);
            logic [FDW-1:0] fd_cnt;

            // Counts cycles spent in active mode, saturating
            always_ff @(posedge clk) begin
                if (!rst_n)                 fd_cnt <= '0;
                else if (mode_o != M_NORMAL) fd_cnt <= '0;
                else if (fd_cnt != FD_MAX)   fd_cnt <= fd_cnt + 1'b1;
            end

            assign tx_ready_o = (mode_o == M_NORMAL) && (fd_cnt == FD_MAX);
        end
    endgenerate

endmodule

// File: rtl/lin_mode_ctrl.sv
// LIN transceiver mode controller, top level.
// Combines the mode sequencer, toggle detector and dominant guard, and forms
// the transmit command, receive level/enable and inhibit enable.
// Assumes: all inputs synchronized and debounced; SLEEP_DLY > 3*STEP_MAX.
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int FIRST_DOM = 4,
    parameter int SLEEP_DLY = 40,
    parameter int DOM_TMO   = 40,
    parameter int FLAG_LEN  = 6,
    parameter int STEP_MAX  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic txd_i,
    input  logic bus_rx_i,
    input  logic wake_i,
    input  logic uv_i,
    input  logic lin_tsd_i,
    input  logic inh_tsd_i,
    output logic tx_cmd_o,
    output logic rxd_o,
    output logic rxd_oe_o,
    output logic inh_en_o,
    output logic fast_o
);
    mode_e mode;
    logic  tx_ready;
    logic  flag_act;
    logic  flag_lvl;
    logic  seq_done;
    logic  dom_block;
    logic  asleep;
    logic  thermal;

    lin_mode_fsm #(
        .FIRST_DOM (FIRST_DOM),
        .SLEEP_DLY (SLEEP_DLY),
        .FLAG_LEN  (FLAG_LEN)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .wake_i     (wake_i),
        .bus_rx_i   (bus_rx_i),
        .seq_done_i (seq_done),
        .mode_o     (mode),
        .tx_ready_o (tx_ready),
        .fast_o     (fast_o),
        .flag_act_o (flag_act),
        .flag_lvl_o (flag_lvl)
    );

    lin_fbr_seq #(
        .STEP_MAX (STEP_MAX)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .txd_i    (txd_i),
        .arm_ok_i (mode == M_NORMAL),
        .abort_i  (mode == M_SLEEP),
        .done_o   (seq_done)
    );

    lin_dom_guard #(
        .DOM_TMO (DOM_TMO)
    ) guard_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd_i   (txd_i),
        .block_o (dom_block)
    );

    assign asleep  = (mode == M_SLEEP);
    assign thermal = lin_tsd_i || inh_tsd_i;

    // Transmit command: dominant only when every gate allows it
    always_comb begin
        tx_cmd_o = !(tx_ready && !txd_i && !dom_block && !uv_i && !thermal);
    end

    // Inhibit switch and receive output enable
    always_comb begin
        inh_en_o = !asleep && !thermal;
        rxd_oe_o = !asleep;
    end

    // Receive level, highest-priority override first
    always_comb begin
        if (asleep)              rxd_o = 1'b1;
        else if (thermal)        rxd_o = 1'b1;
        else if (mode == M_WAKE) rxd_o = 1'b0;
        else if (flag_act)       rxd_o = flag_lvl;
        else                     rxd_o = bus_rx_i;
    end

endmodule

// File: rtl/lin_mode_ctrl_chk.sv
// Property checker for lin_mode_ctrl, attached with bind below.
// Relates the top-level ports to each other over time.
module lin_mode_ctrl_chk #(
    parameter int DOM_TMO = 40
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic uv_i,
    input logic lin_tsd_i,
    input logic inh_tsd_i,
    input logic tx_cmd_o,
    input logic rxd_o,
    input logic rxd_oe_o,
    input logic inh_en_o,
    input logic fast_o
);
    localparam int CW = $clog2(DOM_TMO + 2);
    localparam logic [CW-1:0] CMAX = CW'(DOM_TMO + 1);
    localparam logic [CW-1:0] CLIM = CW'(DOM_TMO);

    logic [CW-1:0] dom_run;

    // Length of the current dominant run on the transmit command
    always_ff @(posedge clk) begin
        if (!rst_n)               dom_run <= '0;
        else if (tx_cmd_o)        dom_run <= '0;
        else if (dom_run != CMAX) dom_run <= dom_run + 1'b1;
    end

    // R8
    uv_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |-> tx_cmd_o);

    // R4
    sleep_inh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rxd_oe_o |-> (!inh_en_o && tx_cmd_o));

    // R9
    lin_tsd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_tsd_i |-> (tx_cmd_o && !inh_en_o && (rxd_o || !rxd_oe_o)));

    // R10
    inh_tsd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inh_tsd_i |-> (!inh_en_o && tx_cmd_o));

    // R7
    dom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_cmd_o |-> (dom_run < CLIM));

    // R6
    wake_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rxd_oe_o) && !$past(en_i) && !lin_tsd_i && !inh_tsd_i) |-> !rxd_o);

    // R11
    fast_entry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fast_o) && !lin_tsd_i && !inh_tsd_i) |-> !rxd_o);

    // R12
    fast_exit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fast_o) && rxd_oe_o) |-> rxd_o);

endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk #(
    .DOM_TMO (DOM_TMO)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .uv_i      (uv_i),
    .lin_tsd_i (lin_tsd_i),
    .inh_tsd_i (inh_tsd_i),
    .tx_cmd_o  (tx_cmd_o),
    .rxd_o     (rxd_o),
    .rxd_oe_o  (rxd_oe_o),
    .inh_en_o  (inh_en_o),
    .fast_o    (fast_o)
);

// File: tb/lin_mode_ctrl_tb_top.sv
// Self-checking bench for lin_mode_ctrl.
module lin_mode_ctrl_tb_top;
    localparam int FIRST_DOM = 4;
    localparam int SLEEP_DLY = 40;
    localparam int DOM_TMO   = 40;
    localparam int FLAG_LEN  = 6;
    localparam int STEP_MAX  = 8;

    // {txd, bus, uv, lin_tsd, inh_tsd, exp_tx, exp_rxd, exp_inh}
    localparam int NVEC = 11;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b11000111, 8'b00000001, 8'b01000011, 8'b10000101,
        8'b00100101, 8'b00010110, 8'b10010110, 8'b00001110,
        8'b00011110, 8'b00000001, 8'b11100111
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, txd = 1'b1, bus = 1'b1, wake = 1'b0;
    logic uv = 1'b0, ltsd = 1'b0, itsd = 1'b0;
    logic tx_cmd, rxd, rxd_oe, inh_en, fast;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    lin_mode_ctrl #(
        .FIRST_DOM (FIRST_DOM),
        .SLEEP_DLY (SLEEP_DLY),
        .DOM_TMO   (DOM_TMO),
        .FLAG_LEN  (FLAG_LEN),
        .STEP_MAX  (STEP_MAX)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .txd_i     (txd),
        .bus_rx_i  (bus),
        .wake_i    (wake),
        .uv_i      (uv),
        .lin_tsd_i (ltsd),
        .inh_tsd_i (itsd),
        .tx_cmd_o  (tx_cmd),
        .rxd_o     (rxd),
        .rxd_oe_o  (rxd_oe),
        .inh_en_o  (inh_en),
        .fast_o    (fast)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Toggle sequence with a gap of g cycles between steps
    task automatic toggle(input int g);
        en = 1'b0;
        cyc(g);
        txd = 1'b0;
        cyc(g);
        txd = 1'b1;
        cyc(g);
        en = 1'b1;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "tx_cmd", tx_cmd, 1'b1);
        chk("R1", "rxd_oe", rxd_oe, 1'b1);
        chk("R1", "inh_en", inh_en, 1'b1);
        chk("R1", "fast", fast, 1'b0);
        chk("R1", "rxd", rxd, 1'b1);

        // R3 settling delay after entering active mode
        en = 1'b1;
        txd = 1'b0;
        cyc(FIRST_DOM);
        chk("R3", "tx_cmd before delay", tx_cmd, 1'b1);
        cyc(1);
        chk("R3", "tx_cmd after delay", tx_cmd, 1'b0);
        txd = 1'b1;
        cyc(1);

        // R2 R8 R9 R10 vector table
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            txd  = VEC[i][7];
            bus  = VEC[i][6];
            uv   = VEC[i][5];
            ltsd = VEC[i][4];
            itsd = VEC[i][3];
            tag = ltsd ? "R9" : (itsd ? "R10" : (uv ? "R8" : "R2"));
            cyc(1);
            chk(tag, "tx_cmd", tx_cmd, VEC[i][2]);
            chk(tag, "rxd", rxd, VEC[i][1]);
            chk(tag, "inh_en", inh_en, VEC[i][0]);
        end
        txd = 1'b1; bus = 1'b1; uv = 1'b0; ltsd = 1'b0; itsd = 1'b0;
        cyc(2);

        // R7 dominant timeout, R14 release only after recessive
        txd = 1'b0;
        #1;
        chk("R7", "tx_cmd at start", tx_cmd, 1'b0);
        cyc(DOM_TMO - 1);
        chk("R7", "tx_cmd last dominant", tx_cmd, 1'b0);
        cyc(1);
        chk("R7", "tx_cmd released", tx_cmd, 1'b1);
        cyc(3);
        chk("R14", "tx_cmd while still low", tx_cmd, 1'b1);
        txd = 1'b1;
        cyc(1);
        txd = 1'b0;
        #1;
        chk("R14", "tx_cmd resumed", tx_cmd, 1'b0);
        txd = 1'b1;
        cyc(2);

        // R11 fast entry
        toggle(2);
        cyc(1);
        chk("R11", "fast", fast, 1'b1);
        chk("R11", "rxd flag start", rxd, 1'b0);
        cyc(FLAG_LEN - 1);
        chk("R11", "rxd flag end", rxd, 1'b0);
        cyc(1);
        chk("R11", "rxd after flag", rxd, 1'b1);

        // R12 fast exit with bus dominant
        bus = 1'b0;
        toggle(2);
        cyc(1);
        chk("R12", "fast", fast, 1'b0);
        chk("R12", "rxd flag start", rxd, 1'b1);
        cyc(FLAG_LEN - 1);
        chk("R12", "rxd flag end", rxd, 1'b1);
        cyc(1);
        chk("R12", "rxd after flag", rxd, 1'b0);
        bus = 1'b1;
        cyc(2);

        // R13 wrong order: transmit low before enable falls
        txd = 1'b0;
        cyc(1);
        en = 1'b0;
        cyc(2);
        txd = 1'b1;
        cyc(2);
        en = 1'b1;
        cyc(1);
        chk("R13", "fast after wrong order", fast, 1'b0);
        chk("R13", "rxd after wrong order", rxd, 1'b1);
        cyc(2);
        // R13 too slow
        toggle(STEP_MAX + 2);
        cyc(1);
        chk("R13", "fast after slow sequence", fast, 1'b0);
        chk("R13", "rxd after slow sequence", rxd, 1'b1);
        cyc(2);

        // R4 sleep entry
        en = 1'b0;
        cyc(SLEEP_DLY);
        chk("R4", "rxd_oe before window end", rxd_oe, 1'b1);
        cyc(1);
        chk("R4", "rxd_oe asleep", rxd_oe, 1'b0);
        chk("R4", "inh_en asleep", inh_en, 1'b0);
        chk("R4", "tx_cmd asleep", tx_cmd, 1'b1);

        // R6 wake by wake pin
        wake = 1'b1;
        cyc(1);
        chk("R6", "rxd_oe wake pin", rxd_oe, 1'b1);
        chk("R6", "rxd wake pin", rxd, 1'b0);
        en = 1'b1;
        cyc(1);
        chk("R6", "rxd back in active", rxd, 1'b1);

        // R6 wake by bus
        en = 1'b0;
        cyc(SLEEP_DLY + 1);
        chk("R4", "rxd_oe asleep again", rxd_oe, 1'b0);
        bus = 1'b0;
        cyc(1);
        chk("R6", "rxd_oe bus wake", rxd_oe, 1'b1);
        chk("R6", "rxd bus wake", rxd, 1'b0);
        bus = 1'b1;
        en = 1'b1;
        cyc(2);

        // R5 wake change abandons sleep entry
        en = 1'b0;
        cyc(5);
        wake = 1'b0;
        cyc(SLEEP_DLY + 2);
        chk("R5", "rxd_oe stays on", rxd_oe, 1'b1);
        chk("R5", "inh_en stays on", inh_en, 1'b1);
        en = 1'b1;
        cyc(2);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule